// File: doc/BRIEF.md
# Lockable Control Register Bank

This block is a small word-addressed register bank that sits beside a serial receive/transmit path. It holds a control word with three parts: a 16-entry history of oversampled receive line values that hardware fills, an enable bit that starts and stops that history capture, and a 2-bit code that selects the transmit interrupt trigger level. It also holds a parameterised number of general guarded configuration words. The field values and a decoded trigger threshold (1, 4, 8 or 16 characters) go out as plain signals to the receiver, baud and interrupt logic. That logic lives outside the block.

A one-bit lock register guards every software-writable control word. The lock comes out of reset set, which means writes are allowed. Software clears it by writing a one, and after that it cannot be set again until the next reset. While the lock is clear, writes to the guarded words are dropped without any error. The history capture keeps running while the lock is clear. Accesses to addresses that decode to no register return zero and raise a one-cycle error flag.

Bus timing is simple. A request is sampled on a clock edge. Writes take effect on that edge. The read data and the error flag appear as registered outputs in the following cycle.

Top module: `bnkctl_bank`

## Requirements
- R1: After reset the lock reads 1, the control word reads 0x0010_0000 (capture disabled, trigger code 2, history zero), every guarded configuration word reads 0, and `tx_thresh` is 8.
- R2: Address 0 holds the lock in bit 0. Writing a word with bit 0 = 1 clears the lock. Writing bit 0 = 0 leaves it unchanged. No write sets it again before reset.
- R3: A write to the control word (address 1) or to any configuration word (addresses 2 to 1+NUM_AUX) changes it only while the lock is 1. While the lock is 0 the write is dropped and `bus_err` stays 0.
- R4: The single lock bit guards the control word and every configuration word together.
- R5: Control word layout: bits 15:0 are the history, bit 16 is the capture enable, bits 20:19 are the trigger code. Bits 17, 18 and 31:21 always read 0 and ignore writes. Configuration-word bits at or above AUX_W also read 0.
- R6: Software cannot write the history. On each cycle with `ovs_tick` = 1 while the enable is 1, the history shifts toward bit 15 and `rx_sample` enters bit 0.
- R7: While the enable is 0, the history holds its value regardless of `ovs_tick`.
- R8: `tx_thresh` decodes trigger codes 0, 1, 2, 3 to 1, 4, 8, 16. `tx_level` and `cap_en` mirror the stored fields.
- R9: Read data appears on `bus_rdata` in the cycle after the read request. In any cycle that does not follow a read, `bus_rdata` is 0.
- R10: A read or write to an unmapped address (2+NUM_AUX and above) returns 0, changes no state, and sets `bus_err` for exactly the following cycle. Mapped accesses leave `bus_err` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle unmapped-access flag |
| rx_sample | input | 1 | Oversampled receive line value |
| ovs_tick | input | 1 | Oversample strobe |
| lock_open | output | 1 | Current lock bit |
| cap_en | output | 1 | Capture enable field |
| tx_level | output | 2 | Trigger code field |
| tx_thresh | output | 5 | Decoded trigger threshold in characters |
| aux_cfg | output | NUM_AUX*AUX_W | Guarded configuration words, word i at bits i*AUX_W |

## Verification
A lock bit that is wrongly set or cleared shows up at the next guarded write. The following read-back returns either the new data or the old data, which is one cycle after the read request, and `lock_open` shows the lock at once. A history register that shifts when it should not, or that takes the wrong bit, differs from a model in the bench on the next read of the control word. A faulty level register changes `tx_thresh` on the cycle after the write. A decode error shows as a missing or stray `bus_err` pulse, or as non-zero data one cycle after the request.

// File: rtl/bnkctl_pkg.sv
// Package: shared constants and the trigger-level decode for the register bank.
// Assumes a 32-bit data word; field positions are fixed by the external decoder.
package bnkctl_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_LOCK = 0;
    localparam int ADDR_CTRL = 1;
    localparam int AUX_BASE  = 2;
    localparam int HIST_W    = 16;
    localparam int EN_BIT    = 16;
    localparam int LVL_LSB   = 19;
    localparam int LVL_W     = 2;
    localparam int THR_W     = 5;
    localparam logic [LVL_W-1:0] LVL_RESET = 2'd2;

    // Map a trigger code onto a threshold in characters.
    function automatic logic [THR_W-1:0] lvl_to_thresh(input logic [LVL_W-1:0] code);
        logic [THR_W-1:0] t;
        case (code)
            2'd0:    t = 5'd1;
            2'd1:    t = 5'd4;
            2'd2:    t = 5'd8;
            default: t = 5'd16;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/bnkctl_lock.sv
// Module: one-bit write-enable lock, clear-only by writing a one.
// Assumes clr_req is a decoded write strobe to the lock address.
module bnkctl_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    input  logic clr_bit,
    output logic lock_q
);
    // Lock state: set by reset, cleared by a write of one, never set by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b1;
        else if (clr_req && clr_bit)
            lock_q <= 1'b0;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !lock_q); // R2
endmodule

// File: rtl/bnkctl_guard_reg.sv
// Module: software-writable register whose writes are honoured only while allowed.
// Assumes wr_req is a decoded write strobe and allow reflects the lock bit.
module bnkctl_guard_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic         allow,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Storage: reset value, then software data while the lock is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (wr_req && allow)
            q <= wdata;
    end

    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req || !allow) |=> $stable(q)); // R3
endmodule

// File: rtl/bnkctl_hist.sv
// Module: oversample history shift register, filled by hardware only.
// Assumes tick is a single-cycle strobe in the clk domain.
module bnkctl_hist #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         sample,
    output logic [W-1:0] hist
);
    // Shift: newest sample into bit 0 on an enabled strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (tick && en)
            hist <= {hist[W-2:0], sample};
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && en) |=> $stable(hist)); // R7
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en) |=> (hist[W-1:1] == $past(hist[W-2:0])) && (hist[0] == $past(sample))); // R6
endmodule

// File: rtl/bnkctl_bank.sv
// Module: lockable control register bank top.
// Decodes word addresses, applies the lock to guarded writes, assembles read
// data with reserved bits forced to zero, and exports field values.
// Assumes ADDR_W can cover AUX_BASE+NUM_AUX addresses and AUX_W <= 32.
module bnkctl_bank
    import bnkctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_AUX = 2,
    parameter int AUX_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     bus_err,
    input  logic                     rx_sample,
    input  logic                     ovs_tick,
    output logic                     lock_open,
    output logic                     cap_en,
    output logic [LVL_W-1:0]         tx_level,
    output logic [THR_W-1:0]         tx_thresh,
    output logic [NUM_AUX*AUX_W-1:0] aux_cfg
);
    localparam int CTRL_W = LVL_W + 1;
    localparam logic [CTRL_W-1:0] CTRL_RESET = {LVL_RESET, 1'b0};

    logic                wr_stb;
    logic                rd_stb;
    logic                hit_lock;
    logic                hit_ctrl;
    logic [NUM_AUX-1:0]  hit_aux;
    logic                unmapped;
    logic                lock_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [HIST_W-1:0]   hist_q;
    logic [AUX_W-1:0]    aux_q [NUM_AUX];
    logic [DATA_W-1:0]   ctrl_word;
    logic [DATA_W-1:0]   rd_mux;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Strobes: qualify the request by direction.
    assign wr_stb = bus_valid && bus_write;
    assign rd_stb = bus_valid && !bus_write;

    // Decode: one hit line per mapped word, unmapped when none match.
    always_comb begin
        hit_lock = (bus_addr == ADDR_W'(ADDR_LOCK));
        hit_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
        for (int i = 0; i < NUM_AUX; i++)
            hit_aux[i] = (bus_addr == ADDR_W'(AUX_BASE + i));
        unmapped = !(hit_lock || hit_ctrl || (|hit_aux));
    end

    bnkctl_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_req (wr_stb && hit_lock),
        .clr_bit (bus_wdata[0]),
        .lock_q  (lock_q)
    );

    bnkctl_guard_reg #(
        .W         (CTRL_W),
        .RESET_VAL (CTRL_RESET)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_req(wr_stb && hit_ctrl),
        .allow (lock_q),
        .wdata ({bus_wdata[LVL_LSB+LVL_W-1:LVL_LSB], bus_wdata[EN_BIT]}),
        .q     (ctrl_q)
    );

    bnkctl_hist #(
        .W (HIST_W)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ovs_tick),
        .en     (ctrl_q[0]),
        .sample (rx_sample),
        .hist   (hist_q)
    );

    for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
        bnkctl_guard_reg #(
            .W         (AUX_W),
            .RESET_VAL ('0)
        ) u_aux (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_req(wr_stb && hit_aux[g]),
            .allow (lock_q),
            .wdata (bus_wdata[AUX_W-1:0]),
            .q     (aux_q[g])
        );
        assign aux_cfg[g*AUX_W +: AUX_W] = aux_q[g];
    end

    // Control word: fields at fixed positions, reserved bits zero.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[HIST_W-1:0] = hist_q;
        ctrl_word[EN_BIT] = ctrl_q[0];
        ctrl_word[LVL_LSB +: LVL_W] = ctrl_q[CTRL_W-1:1];
    end

    // Read mux: selected word, zero for unmapped addresses.
    always_comb begin
        rd_mux = '0;
        if (hit_lock)
            rd_mux[0] = lock_q;
        if (hit_ctrl)
            rd_mux = ctrl_word;
        for (int i = 0; i < NUM_AUX; i++)
            if (hit_aux[i])
                rd_mux = DATA_W'(aux_q[i]);
    end

    // Response: registered data on reads, one-cycle error on unmapped access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_stb ? rd_mux : '0;
            bus_err   <= bus_valid && unmapped;
        end
    end

    // Field export to the receive, baud and interrupt logic.
    assign lock_open = lock_q;
    assign cap_en    = ctrl_q[0];
    assign tx_level  = ctrl_q[CTRL_W-1:1];
    assign tx_thresh = lvl_to_thresh(ctrl_q[CTRL_W-1:1]);

    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && unmapped) |=> bus_err); // R10
    AST_MAPPED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && unmapped) |=> !bus_err); // R10
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (bus_rdata == '0)); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && hit_ctrl) |=> (bus_rdata[31:21] == '0) && (bus_rdata[18:17] == '0)); // R5
    AST_THRESH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && hit_ctrl && lock_q) |=> (tx_level == $past(bus_wdata[20:19]))); // R8
endmodule

// File: tb/tb_bnkctl_bank.sv
`timescale 1ns/100ps
// Bench: directed scenarios for the lockable register bank, one task each.
module tb_bnkctl_bank;
    localparam int ADDR_W  = 4;
    localparam int NUM_AUX = 2;
    localparam int AUX_W   = 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     bus_valid = 1'b0;
    logic                     bus_write = 1'b0;
    logic [ADDR_W-1:0]        bus_addr = '0;
    logic [31:0]              bus_wdata = '0;
    logic [31:0]              bus_rdata;
    logic                     bus_err;
    logic                     rx_sample = 1'b0;
    logic                     ovs_tick = 1'b0;
    logic                     lock_open;
    logic                     cap_en;
    logic [1:0]               tx_level;
    logic [4:0]               tx_thresh;
    logic [NUM_AUX*AUX_W-1:0] aux_cfg;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [15:0] exp_hist = '0;

    always #2.5 clk = ~clk;

    bnkctl_bank #(.ADDR_W(ADDR_W), .NUM_AUX(NUM_AUX), .AUX_W(AUX_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rx_sample(rx_sample), .ovs_tick(ovs_tick),
        .lock_open(lock_open), .cap_en(cap_en), .tx_level(tx_level),
        .tx_thresh(tx_thresh), .aux_cfg(aux_cfg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        e = bus_err;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; e = bus_err;
        bus_valid = 1'b0;
    endtask

    task automatic do_tick(input logic s);
        @(negedge clk);
        ovs_tick = 1'b1; rx_sample = s;
        @(negedge clk);
        ovs_tick = 1'b0;
        if (cap_en) exp_hist = {exp_hist[14:0], s};
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        check("R1 thresh", 32'(tx_thresh), 32'd8);
        check("R1 lock_open", 32'(lock_open), 32'd1);
        check("R1 aux_cfg", 32'(aux_cfg), 32'd0);
        check("R9 idle rdata", bus_rdata, 32'd0);
        do_read(4'd0, d, e); check("R1 lock read", d, 32'd1);
        do_read(4'd1, d, e); check("R1 ctrl read", d, 32'h0010_0000);
        do_read(4'd3, d, e); check("R1 aux1 read", d, 32'd0);
    endtask

    task automatic t_fields();
        logic [31:0] d; logic e;
        do_write(4'd1, 32'hFFFF_FFFF, e);
        check("R10 mapped write no err", 32'(e), 32'd0);
        do_read(4'd1, d, e);
        check("R5 R6 reserved and history masked", d, 32'h0019_0000);
        check("R8 thresh code 3", 32'(tx_thresh), 32'd16);
        for (int c = 0; c < 4; c++) begin
            do_write(4'd1, 32'(c) << 19, e);
            check("R8 level mirror", 32'(tx_level), 32'(c));
            check("R8 thresh decode", 32'(tx_thresh), (c == 0) ? 32'd1 : (32'd2 << c));
        end
    endtask

    task automatic t_hist();
        logic [31:0] d; logic e;
        logic [19:0] pat = 20'hB5C3A;
        exp_hist = '0;
        do_write(4'd1, (32'd1 << 16) | (32'd2 << 19), e);
        check("R8 cap_en mirror", 32'(cap_en), 32'd1);
        for (int i = 0; i < 20; i++) do_tick(pat[i]);
        do_read(4'd1, d, e);
        check("R6 history shift", d, 32'h0011_0000 | 32'(exp_hist));
        do_write(4'd1, (32'd2 << 19) | 32'h0000_FFFF, e);
        for (int i = 0; i < 5; i++) do_tick(1'b1);
        do_read(4'd1, d, e);
        check("R7 R6 history held and not writable", d, 32'h0010_0000 | 32'(exp_hist));
    endtask

    task automatic t_aux();
        logic [31:0] d; logic e;
        do_write(4'd2, 32'hDEAD_BEEF, e);
        do_write(4'd3, 32'hFFFF_CAFE, e);
        do_read(4'd2, d, e); check("R5 aux0 upper bits zero", d, 32'h0000_BEEF);
        do_read(4'd3, d, e); check("R5 aux1 upper bits zero", d, 32'h0000_CAFE);
        check("R4 aux_cfg export", 32'(aux_cfg), 32'hCAFE_BEEF);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        do_read(4'd4, d, e);
        check("R10 unmapped read data", d, 32'd0);
        check("R10 unmapped read err", 32'(e), 32'd1);
        @(negedge clk);
        check("R10 err one cycle", 32'(bus_err), 32'd0);
        check("R9 rdata zero after read", bus_rdata, 32'd0);
        do_write(4'd15, 32'hFFFF_FFFF, e);
        check("R10 unmapped write err", 32'(e), 32'd1);
        do_read(4'd3, d, e);
        check("R10 no state change", d, 32'h0000_CAFE);
        check("R10 mapped read no err", 32'(e), 32'd0);
    endtask

    task automatic t_lock();
        logic [31:0] d; logic e;
        do_write(4'd1, (32'd1 << 16) | (32'd1 << 19), e);
        check("R8 thresh code 1", 32'(tx_thresh), 32'd4);
        do_write(4'd0, 32'hFFFF_FFFE, e);
        do_read(4'd0, d, e); check("R2 write zero keeps lock", d, 32'd1);
        do_write(4'd0, 32'd1, e);
        check("R2 lock clear no err", 32'(e), 32'd0);
        do_read(4'd0, d, e); check("R2 lock cleared", d, 32'd0);
        check("R2 lock_open port", 32'(lock_open), 32'd0);
        do_write(4'd1, 32'h0018_0000, e);
        check("R3 locked write no err", 32'(e), 32'd0);
        check("R3 thresh unchanged", 32'(tx_thresh), 32'd4);
        do_write(4'd2, 32'h0000_1234, e);
        do_write(4'd3, 32'h0000_5678, e);
        check("R4 aux writes dropped", 32'(aux_cfg), 32'hCAFE_BEEF);
        do_tick(1'b1); do_tick(1'b0); do_tick(1'b1);
        do_read(4'd1, d, e);
        check("R3 R6 ctrl kept, history runs", d, 32'h0009_0000 | 32'(exp_hist));
        do_write(4'd0, 32'd1, e);
        do_write(4'd0, 32'd0, e);
        do_read(4'd0, d, e); check("R2 lock stays clear", d, 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_hist();
        t_aux();
        t_unmapped();
        t_lock();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule